// File: doc/BRIEF.md
# Eight-Bit PWM Timer/Counter

An 8-bit timer/counter whose counting sequence is chosen by a 3-bit mode field. It can run as a plain wrapping counter, as a counter that clears on a compare value, as a single-slope (fast) PWM generator or as a dual-slope (phase-correct) PWM generator. The upper count limit is either fixed at 0xFF or taken from compare register A. Two compare channels, A and B, each drive a waveform pin and raise a sticky match flag. A separate overflow flag marks the wrap point of each mode.

Software reaches the block through a small synchronous register port: a write strobe, a 3-bit address and a data byte, plus a combinational read bus. A one-cycle `tick_i` pulse stands in for a prescaler, and the counter moves only on cycles where it is high. In the PWM modes, compare values are double-buffered. A write lands in a buffer and is copied into the active compare value at a point that depends on the mode. In the non-PWM modes, a write takes effect at once.

Top module: `pwm_timer8`

## Requirements
- R1: Register map (address: content). 0: bits 7:6 channel A output code, bits 5:4 channel B output code, bits 3:2 always read 0, bits 1:0 mode bits 1:0. 1: bit 0 is mode bit 2 and the other bits read 0. 2 and 3: compare A and compare B. 4: counter. 5: flags (bit 0 overflow, bit 1 match A, bit 2 match B). 6 and 7 read 0. Everything resets to 0.
- R2: The counter changes only on a cycle with `tick_i` high, or through a write to address 4. That write loads the value and suppresses the cycle's tick, including the tick's flag and pin events.
- R3: Mode 0 (normal) counts 0x00 to 0xFF and wraps. The overflow flag is set on the tick taken at 0xFF. Compare writes take effect at once.
- R4: Mode 2 (clear on compare) wraps to 0 on the tick taken at compare A. Compare writes take effect at once. The overflow flag is set on the tick taken at 0xFF.
- R5: Modes 3 and 7 (fast PWM) count 0 to TOP and then wrap to 0, where TOP is 0xFF in mode 3 and active compare A in mode 7. On the wrapping tick, the buffered compare values become active. Overflow is set on the tick taken at 0xFF in mode 3, and at TOP in mode 7.
- R6: Modes 1 and 5 (phase-correct) count up to TOP, then down to 0, then up again. TOP is 0xFF in mode 1 and active compare A in mode 5. Each extreme value is held for one tick. Buffered compare values become active on the tick taken at TOP while counting up. Overflow is set on the tick taken at 0.
- R7: A match flag is set on a tick where the counter equals that channel's active compare value. Writing a 1 to a flag bit at address 5 clears it. If a set and a clear happen in the same cycle, the set wins.
- R8: In fast PWM, output code 2 clears the pin on a match and sets it on the wrapping tick. Code 3 does the inverse. When the match and the wrap fall on the same tick, the wrap action wins.
- R9: In phase-correct PWM, output code 2 clears the pin on a match while counting up and sets it on a match while counting down. Code 3 does the inverse.
- R10: Output codes 0 and 1 hold the pin low. In modes 0 and 2, both pins are low.
- R11: Modes 4 and 6 are reserved: the counter holds its value and raises no flags.
- R12: Reads of addresses 2 and 3 return the last value written (the buffer), not the active value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable pulse |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i |
| wave_a_o | output | 1 | Channel A waveform |
| wave_b_o | output | 1 | Channel B waveform |
| ovf_o | output | 1 | Overflow flag |
| match_a_o | output | 1 | Channel A match flag |
| match_b_o | output | 1 | Channel B match flag |

## Verification
Some properties are checked on every cycle. The counter holds when there is no tick and in the reserved modes. A fast-PWM counter at TOP returns to zero, and a phase-correct counter only ever steps by one. The overflow flag stays set until cleared, disconnected pins stay low, and the reserved bits of address 0 read zero. Other behaviour can only be shown by the bench's scenarios against its reference model: when buffered compare values take effect, whether a pin toggles in the right direction on a match, the duty cycle when compare equals TOP, and flag set-versus-clear priority.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [2:0] {
    MD_NORMAL  = 3'd0,
    MD_PC_FF   = 3'd1,
    MD_CTC     = 3'd2,
    MD_FAST_FF = 3'd3,
    MD_RSV4    = 3'd4,
    MD_PC_A    = 3'd5,
    MD_RSV6    = 3'd6,
    MD_FAST_A  = 3'd7
  } mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL_A = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL_B = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP_A  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_B  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT    = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd5;

  function automatic logic is_phase(mode_e m);
    return (m == MD_PC_FF) || (m == MD_PC_A);
  endfunction

  function automatic logic is_fast(mode_e m);
    return (m == MD_FAST_FF) || (m == MD_FAST_A);
  endfunction

  function automatic logic top_from_a(mode_e m);
    return (m == MD_CTC) || (m == MD_PC_A) || (m == MD_FAST_A);
  endfunction

  function automatic logic is_imm(mode_e m);
    return (m == MD_NORMAL) || (m == MD_CTC);
  endfunction

  function automatic logic is_rsv(mode_e m);
    return (m == MD_RSV4) || (m == MD_RSV6);
  endfunction
endpackage

// File: rtl/pwm_cnt_unit.sv
module pwm_cnt_unit #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          phase_i,
  input  logic [DW-1:0] top_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic          dir_up_o
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] cnt_q, cnt_n;
  logic          dir_q, dir_n;
  logic          at_top, at_bot, top_zero;

  assign at_top   = (cnt_q == top_i);
  assign at_bot   = (cnt_q == '0);
  assign top_zero = (top_i == '0);

  always_comb begin
    cnt_n = cnt_q + ONE;
    dir_n = dir_q;
    if (phase_i) begin
      if (dir_q) begin
        if (at_top) begin
          cnt_n = top_zero ? '0 : cnt_q - ONE;
          dir_n = 1'b0;
        end
      end else begin
        if (at_bot) begin
          cnt_n = top_zero ? '0 : ONE;
          dir_n = 1'b1;
        end else begin
          cnt_n = cnt_q - ONE;
        end
      end
    end else if (at_top) begin
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (wr_i) begin
      cnt_q <= wdata_i;
    end else if (run_i) begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end
  end

  assign cnt_o    = cnt_q;
  assign dir_up_o = dir_q;
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          imm_i,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          run_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          at_top_i,
  input  logic          phase_i,
  input  logic          fast_i,
  input  logic          dir_up_i,
  input  logic [1:0]    com_i,
  input  logic          clr_i,
  output logic [DW-1:0] buf_o,
  output logic [DW-1:0] act_o,
  output logic          flag_o,
  output logic          wave_o
);
  logic [DW-1:0] buf_q, act_q;
  logic          flag_q, pin_q, match;

  assign match = run_i && (cnt_i == act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      act_q  <= '0;
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      if (wr_i) buf_q <= wdata_i;
      if (wr_i && imm_i) act_q <= wdata_i;
      else if (load_i)   act_q <= buf_q;
      flag_q <= (flag_q && !clr_i) || match;
      if (run_i && com_i[1]) begin
        if (fast_i) begin
          if (at_top_i)   pin_q <= ~com_i[0];  // wrap wins over match
          else if (match) pin_q <= com_i[0];
        end else if (phase_i && match) begin
          pin_q <= dir_up_i ? com_i[0] : ~com_i[0];
        end
      end
    end
  end

  assign buf_o  = buf_q;
  assign act_o  = act_q;
  assign flag_o = flag_q;
  assign wave_o = com_i[1] && (fast_i || phase_i) && pin_q;
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              wave_a_o,
  output logic              wave_b_o,
  output logic              ovf_o,
  output logic              match_a_o,
  output logic              match_b_o
);
  localparam int NCH = 2;

  logic [5:0]    ctrl_a_q;
  logic          ctrl_b_q;
  logic          ovf_q;
  mode_e         mode;
  logic [DW-1:0] cnt, top_val;
  logic          dir_up, run, cnt_wr, at_top, load, ovf_evt;
  logic          phase, fast;
  logic [2:0]    clr;

  logic [DW-1:0] buf_v  [NCH];
  logic [DW-1:0] act_v  [NCH];
  logic [1:0]    com_v  [NCH];
  logic          flag_v [NCH];
  logic          wave_v [NCH];

  assign mode     = mode_e'({ctrl_b_q, ctrl_a_q[1:0]});
  assign phase    = is_phase(mode);
  assign fast     = is_fast(mode);
  assign top_val  = top_from_a(mode) ? act_v[0] : '1;
  assign cnt_wr   = wr_i && (addr_i == A_CNT);
  assign run      = tick_i && !is_rsv(mode) && !cnt_wr;
  assign at_top   = (cnt == top_val);
  assign load     = run && at_top && (fast || (phase && dir_up));
  assign ovf_evt  = run && (phase ? (cnt == '0)
                          : (mode == MD_FAST_A) ? at_top : (cnt == '1));
  assign clr      = (wr_i && addr_i == A_FLAGS) ? wdata_i[2:0] : 3'b000;
  assign com_v[0] = ctrl_a_q[5:4];
  assign com_v[1] = ctrl_a_q[3:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_CTRL_A) ctrl_a_q <= {wdata_i[7:4], wdata_i[1:0]};
      if (wr_i && addr_i == A_CTRL_B) ctrl_b_q <= wdata_i[0];
      ovf_q <= (ovf_q && !clr[0]) || ovf_evt;
    end
  end

  pwm_cnt_unit #(.DW(DW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .phase_i  (phase),
    .top_i    (top_val),
    .wr_i     (cnt_wr),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt),
    .dir_up_o (dir_up)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_ADDR = A_CMP_A + ADDR_W'(i);
    pwm_cmp_chan #(.DW(DW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_i && addr_i == CH_ADDR),
      .imm_i    (is_imm(mode)),
      .load_i   (load),
      .wdata_i  (wdata_i),
      .run_i    (run),
      .cnt_i    (cnt),
      .at_top_i (at_top),
      .phase_i  (phase),
      .fast_i   (fast),
      .dir_up_i (dir_up),
      .com_i    (com_v[i]),
      .clr_i    (clr[i+1]),
      .buf_o    (buf_v[i]),
      .act_o    (act_v[i]),
      .flag_o   (flag_v[i]),
      .wave_o   (wave_v[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL_A: rdata_o[7:0] = {ctrl_a_q[5:2], 2'b00, ctrl_a_q[1:0]};
      A_CTRL_B: rdata_o[0]   = ctrl_b_q;
      A_CMP_A:  rdata_o      = buf_v[0];
      A_CMP_B:  rdata_o      = buf_v[1];
      A_CNT:    rdata_o      = cnt;
      A_FLAGS:  rdata_o[2:0] = {flag_v[1], flag_v[0], ovf_q};
      default:  rdata_o      = '0;
    endcase
  end

  assign wave_a_o  = wave_v[0];
  assign wave_b_o  = wave_v[1];
  assign ovf_o     = ovf_q;
  assign match_a_o = flag_v[0];
  assign match_b_o = flag_v[1];
endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk
  import pwm_timer8_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_i,
  input logic              wave_a_i,
  input logic              wave_b_i,
  input logic              ovf_i,
  input logic [2:0]        mode_i,
  input logic [DW-1:0]     cnt_i,
  input logic [DW-1:0]     top_i,
  input logic [1:0]        com_a_i,
  input logic [1:0]        com_b_i
);
  logic cnt_wr, fast, phase, rsv;
  assign cnt_wr = wr_i && (addr_i == A_CNT);
  assign fast   = (mode_i == 3'd3) || (mode_i == 3'd7);
  assign phase  = (mode_i == 3'd1) || (mode_i == 3'd5);
  assign rsv    = (mode_i == 3'd4) || (mode_i == 3'd6);

  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTRL_A) |-> (rdata_i[3:2] == 2'b00));

  p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_wr) |=> $stable(cnt_i));

  p_fast_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast && tick_i && !cnt_wr && cnt_i == top_i) |=> (cnt_i == '0));

  p_phase_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase && tick_i && !cnt_wr && top_i != '0 && cnt_i <= top_i)
    |=> ((cnt_i == $past(cnt_i) + 8'd1) || (cnt_i == $past(cnt_i) - 8'd1)));

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !(wr_i && addr_i == A_FLAGS && wdata_i[0])) |=> ovf_i);

  p_wave_a_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!com_a_i[1] || (!fast && !phase)) |-> !wave_a_i);

  p_wave_b_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!com_b_i[1] || (!fast && !phase)) |-> !wave_b_i);

  p_rsv_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsv && !cnt_wr) |=> $stable(cnt_i));
endmodule

bind pwm_timer8 pwm_timer8_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_i  (rdata_o),
  .wave_a_i (wave_a_o),
  .wave_b_i (wave_b_o),
  .ovf_i    (ovf_o),
  .mode_i   (mode),
  .cnt_i    (cnt),
  .top_i    (top_val),
  .com_a_i  (com_v[0]),
  .com_b_i  (com_v[1])
);

// File: tb/tb_pwm_timer8.sv
`timescale 1ns/1ps
module tb_pwm_timer8;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       wave_a_o, wave_b_o, ovf_o, match_a_o, match_b_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pwm_timer8 dut (
    .clk_i, .rst_ni, .tick_i, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .wave_a_o, .wave_b_o, .ovf_o, .match_a_o, .match_b_o
  );

  // reference model state
  bit [7:0] m_cnt = 0;
  bit       m_dir = 1;
  bit [7:0] m_buf [2] = '{0, 0};
  bit [7:0] m_act [2] = '{0, 0};
  bit       m_pin [2] = '{0, 0};
  bit [2:0] m_flg = 0;
  bit [5:0] m_ca = 0;
  bit       m_cb = 0;

  function automatic bit [2:0] mdl_mode();
    return {m_cb, m_ca[1:0]};
  endfunction

  function automatic bit [1:0] mdl_com(int i);
    return (i == 0) ? m_ca[5:4] : m_ca[3:2];
  endfunction

  function automatic string mode_tag(bit [2:0] md);
    case (md)
      3'd0: return "R3";
      3'd1, 3'd5: return "R6";
      3'd2: return "R4";
      3'd3, 3'd7: return "R5";
      default: return "R11";
    endcase
  endfunction

  function automatic bit mdl_wave(int i);
    bit [2:0] md = mdl_mode();
    bit pwm = (md == 1 || md == 5 || md == 3 || md == 7);
    return mdl_com(i)[1] && pwm && m_pin[i];
  endfunction

  function automatic string wave_tag(int i);
    bit [2:0] md = mdl_mode();
    if (!mdl_com(i)[1]) return "R10";
    if (md == 1 || md == 5) return "R9";
    if (md == 3 || md == 7) return "R8";
    return "R10";
  endfunction

  function automatic bit [7:0] mdl_read(bit [2:0] a);
    case (a)
      3'd0: return {m_ca[5:2], 2'b00, m_ca[1:0]};
      3'd1: return {7'd0, m_cb};
      3'd2: return m_buf[0];
      3'd3: return m_buf[1];
      3'd4: return m_cnt;
      3'd5: return {5'd0, m_flg};
      default: return 8'd0;
    endcase
  endfunction

  function automatic string read_tag(bit [2:0] a);
    case (a)
      3'd0, 3'd1, 3'd6, 3'd7: return "R1";
      3'd2, 3'd3: return "R12";
      3'd4: return mode_tag(mdl_mode());
      default: return "R7";
    endcase
  endfunction

  task automatic model_step();
    bit [2:0] md = mdl_mode();
    bit ph = (md == 1 || md == 5);
    bit fa = (md == 3 || md == 7);
    bit ua = (md == 2 || md == 5 || md == 7);
    bit imm = (md == 0 || md == 2);
    bit rs = (md == 4 || md == 6);
    bit [7:0] top = ua ? m_act[0] : 8'hFF;
    bit cw = wr_i && addr_i == 3'd4;
    bit run = tick_i && !rs && !cw;
    bit at_top = (m_cnt == top);
    bit ld = run && at_top && (fa || (ph && m_dir));
    bit ovf_ev = run && (ph ? (m_cnt == 0) : (md == 7) ? at_top : (m_cnt == 8'hFF));
    bit [1:0] ev;
    bit [2:0] clr = (wr_i && addr_i == 3'd5) ? wdata_i[2:0] : 3'd0;
    bit [7:0] old_buf [2];
    bit old_dir = m_dir;
    for (int i = 0; i < 2; i++) begin
      ev[i] = run && (m_cnt == m_act[i]);
      old_buf[i] = m_buf[i];
    end
    for (int i = 0; i < 2; i++) begin
      bit [1:0] c = mdl_com(i);
      if (run && c[1]) begin
        if (fa) begin
          if (at_top) m_pin[i] = ~c[0];
          else if (ev[i]) m_pin[i] = c[0];
        end else if (ph && ev[i]) begin
          m_pin[i] = old_dir ? c[0] : ~c[0];
        end
      end
    end
    if (cw) m_cnt = wdata_i;
    else if (run) begin
      if (ph) begin
        if (m_dir) begin
          if (at_top) begin m_cnt = (top == 0) ? 8'd0 : m_cnt - 8'd1; m_dir = 0; end
          else m_cnt = m_cnt + 8'd1;
        end else begin
          if (m_cnt == 0) begin m_cnt = (top == 0) ? 8'd0 : 8'd1; m_dir = 1; end
          else m_cnt = m_cnt - 8'd1;
        end
      end else m_cnt = at_top ? 8'd0 : m_cnt + 8'd1;
    end
    for (int i = 0; i < 2; i++) begin
      bit w = wr_i && addr_i == 3'(2 + i);
      if (w) m_buf[i] = wdata_i;
      if (w && imm) m_act[i] = wdata_i;
      else if (ld) m_act[i] = old_buf[i];
    end
    m_flg = (m_flg & ~clr) | {ev[1], ev[0], ovf_ev};
    if (wr_i && addr_i == 3'd0) m_ca = {wdata_i[7:4], wdata_i[1:0]};
    if (wr_i && addr_i == 3'd1) m_cb = wdata_i[0];
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_cnt = 0; m_dir = 1; m_flg = 0; m_ca = 0; m_cb = 0;
      for (int i = 0; i < 2; i++) begin m_buf[i] = 0; m_act[i] = 0; m_pin[i] = 0; end
    end else begin
      model_step();
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check(read_tag(addr_i), "rdata", int'(rdata_o), int'(mdl_read(addr_i)));
    check(wave_tag(0), "wave_a", int'(wave_a_o), int'(mdl_wave(0)));
    check(wave_tag(1), "wave_b", int'(wave_b_o), int'(mdl_wave(1)));
    check(mode_tag(mdl_mode()), "ovf", int'(ovf_o), int'(m_flg[0]));
    check("R7", "match_a", int'(match_a_o), int'(m_flg[1]));
    check("R7", "match_b", int'(match_b_o), int'(m_flg[2]));
  endtask

  task automatic cyc(bit w, bit [2:0] a, bit [7:0] d, bit t);
    wr_i = w; addr_i = a; wdata_i = d; tick_i = t;
    @(negedge clk_i);
    check_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    bit [2:0] modes [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd7, 3'd4, 3'd6};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // reset state
    check("R1", "reset rdata ctrl", int'(rdata_o), 0);
    check("R1", "reset ovf", int'(ovf_o), 0);
    check("R10", "reset wave_a", int'(wave_a_o), 0);
    rst_ni = 1'b1;
    cyc(0, 3'd4, 0, 0);
    check("R1", "reset counter", int'(rdata_o), 0);

    // R1: reserved bits read zero, mode split
    cyc(1, 3'd0, 8'hFF, 0);
    cyc(0, 3'd0, 0, 0);
    check("R1", "ctrl_a readback", int'(rdata_o), 8'hF3);
    cyc(1, 3'd1, 8'hFF, 0);
    cyc(0, 3'd1, 0, 0);
    check("R1", "ctrl_b readback", int'(rdata_o), 8'h01);

    // R2: counter frozen without tick
    cyc(1, 3'd0, 8'h00, 0);
    cyc(1, 3'd1, 8'h00, 0);
    cyc(1, 3'd4, 8'd10, 0);
    repeat (5) cyc(0, 3'd4, 0, 0);
    check("R2", "counter hold", int'(rdata_o), 10);
    repeat (3) cyc(0, 3'd4, 0, 1);
    check("R2", "counter after 3 ticks", int'(rdata_o), 13);
    cyc(1, 3'd4, 8'd40, 1);
    check("R2", "write beats tick", int'(rdata_o), 40);

    // R8 corner: mode 7, compare B == TOP, code 2 gives a constant high
    cyc(1, 3'd2, 8'd5, 0);
    cyc(1, 3'd3, 8'd5, 0);
    cyc(1, 3'd0, 8'b1010_0011, 0);
    cyc(1, 3'd1, 8'd1, 0);
    cyc(1, 3'd4, 8'd0, 0);
    repeat (20) cyc(0, 3'd4, 0, 1);
    for (int k = 0; k < 12; k++) begin
      cyc(0, 3'd4, 0, 1);
      check("R8", "wave_b full duty", int'(wave_b_o), 1);
    end

    // R6 corner: mode 5 with TOP 3, walk the count sequence
    cyc(1, 3'd0, 8'b1000_0001, 0);
    cyc(1, 3'd2, 8'd3, 0);
    cyc(1, 3'd4, 8'd3, 0);
    for (int k = 0; k < 16; k++) cyc(0, 3'd4, 0, 1);

    // random phases per mode
    foreach (modes[mi]) begin
      bit [2:0] md = modes[mi];
      bit [7:0] ca = {4'($urandom), 2'b00, md[1:0]};
      cyc(1, 3'd1, {7'd0, md[2]}, 0);
      cyc(1, 3'd0, ca, 0);
      cyc(1, 3'd2, ($urandom_range(3) == 0) ? 8'($urandom_range(7)) : 8'($urandom_range(255, 8)), 0);
      cyc(1, 3'd3, 8'($urandom), 0);
      cyc(1, 3'd5, 8'h07, 0);
      for (int k = 0; k < 2500; k++) begin
        int r = $urandom_range(63);
        bit t = ($urandom_range(3) != 0);
        bit [2:0] ra = 3'($urandom);
        if (r < 4)       cyc(1, 3'd5, 8'($urandom), t);
        else if (r == 4) cyc(1, 3'd2, 8'($urandom_range(255, 4)), t);
        else if (r == 5) cyc(1, 3'd3, 8'($urandom), t);
        else if (r == 6) cyc(1, 3'd4, 8'($urandom), t);
        else if (r == 7) cyc(1, 3'd0, {4'($urandom), 2'b00, md[1:0]}, t);
        else             cyc(0, ra, 0, t);
      end
    end
    finish_run();
  end
endmodule